// File: doc/BRIEF.md
# Reset-Pin Hold Duration Meter

This block measures how long an external, active-low reset button or pin is held down. The pin is asynchronous to the block's reference clock, so it first passes through a synchronizer. While the synchronized level shows the pin held, a saturating counter advances by one on every reference clock. At the default 25 MHz reference, one count is 40 ns.

The count is kept after the pin is released, so early boot firmware can read it later. Firmware compares the count with its own threshold to decide whether the press was long enough to call for a factory reset. A single write port clears the count through one command bit. The read port always shows the current count, zero-extended to the register width. The threshold comparison and the action that follows are left to firmware.

Top module: `pin_hold_meter`

## Requirements
- R1: While the synchronized pin level is low, the count rises by exactly one on each rising clock edge.
- R2: The pin passes through a two-flop synchronizer. If the pin is low at rising edge k, after a long released period, the count read after edges k and k+1 is unchanged and the count read after edge k+2 is one higher.
- R3: Once the synchronized level is high again, the count keeps its value on every later cycle until a clear write.
- R4: A later assertion of the pin continues counting from the held value, unless a clear write came in between.
- R5: The count saturates at its all-ones value, 2^CNT_W-1, and stays there while the pin remains low.
- R6: A write with wr_en high and wr_data bit 31 set makes the count read 0 after that rising edge.
- R7: When a clear write and an active count fall in the same cycle, the clear wins and the count reads 0.
- R8: A write with wr_data bit 31 clear has no effect on the count.
- R9: rd_data bits [CNT_W-1:0] carry the count, and every bit above them reads 0. With the default CNT_W of 29, these are bits [31:29].
- R10: While rst is high, the count reads 0 and the synchronizer shows the pin as released.
- R11: The default width of 29 bits, with the package constant of 25,000,000 counts per second, covers a press of at least 21 whole seconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (25 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 1 | Asynchronous active-low reset pin being measured |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bit 31 set requests a clear |
| rd_data | output | 32 | Current count in [CNT_W-1:0], zeros above |

## Verification
The hardest state to reach from the ports is saturation, because at 29 bits it takes over five hundred million cycles. The bench therefore instantiates the block with a 10-bit counter and holds the pin low for longer than 1023 cycles. It then clears the count while the pin is still low, which checks both saturation and clear priority. Random pin runs mixed with random writes cover the hold, resume and synchronizer-latency cases against a cycle model in the bench.

// File: rtl/pin_hold_pkg.sv
package pin_hold_pkg;

    // Reference ticks per second at the nominal 25 MHz clock (40 ns per tick)
    localparam int unsigned TICKS_PER_SEC = 25_000_000;

    // Register layout of the access port
    localparam int unsigned REG_WIDTH   = 32;
    localparam int unsigned CLR_CMD_BIT = 31;

    // Synchronized level of the measured pin
    typedef enum logic {
        PIN_HELD = 1'b0,
        PIN_FREE = 1'b1
    } pin_level_e;

    // Control word handed from the register port to the counter
    typedef struct packed {
        logic clear;
        logic run;
    } cnt_ctl_t;

    // Convert a whole number of seconds to reference ticks
    function automatic longint unsigned secs_to_ticks(input int unsigned secs);
        return longint'(secs) * longint'(TICKS_PER_SEC);
    endfunction

endpackage

// File: rtl/pin_hold_sync.sv
module pin_hold_sync
    import pin_hold_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_async,
    output pin_level_e level
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b1;
                    else     chain_q[s] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b1;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign level = pin_level_e'(chain_q[LAST]);

endmodule

// File: rtl/pin_hold_regif.sv
module pin_hold_regif
    import pin_hold_pkg::*;
#(
    parameter int unsigned CNT_W   = 29,
    parameter int unsigned REG_W   = REG_WIDTH,
    parameter int unsigned CLR_BIT = CLR_CMD_BIT
) (
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_en,
    input  pin_level_e       level,
    input  logic [CNT_W-1:0] count,
    output cnt_ctl_t         ctl,
    output logic [REG_W-1:0] rd_data
);

    localparam int unsigned PAD_W = REG_W - CNT_W;

    // Write decode: only the command bit carries meaning
    always_comb begin
        ctl.clear = wr_en & wr_data[CLR_BIT];
        ctl.run   = (level == PIN_HELD);
    end

    // Read path: count in the low field, zeros above it
    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, count};
        end else begin : g_nopad
            assign rd_data = count[REG_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/pin_hold_satcnt.sv
module pin_hold_satcnt
    import pin_hold_pkg::*;
#(
    parameter int unsigned CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;
    logic             at_max;

    assign at_max = (count_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)                    count_q <= '0;
        else if (ctl.clear)         count_q <= '0;
        else if (ctl.run && !at_max) count_q <= count_q + 1'b1;
    end

    assign count = count_q;

endmodule

// File: rtl/pin_hold_meter.sv
module pin_hold_meter
    import pin_hold_pkg::*;
#(
    parameter int unsigned CNT_W       = 29,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pin_n,
    input  logic                 wr_en,
    input  logic [REG_WIDTH-1:0] wr_data,
    output logic [REG_WIDTH-1:0] rd_data
);

    pin_level_e       sync_level;
    cnt_ctl_t         cnt_ctl;
    logic [CNT_W-1:0] cnt_val;

    pin_hold_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_n),
        .level     (sync_level)
    );

    pin_hold_regif #(
        .CNT_W   (CNT_W),
        .REG_W   (REG_WIDTH),
        .CLR_BIT (CLR_CMD_BIT)
    ) u_regif (
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .level   (sync_level),
        .count   (cnt_val),
        .ctl     (cnt_ctl),
        .rd_data (rd_data)
    );

    pin_hold_satcnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .ctl   (cnt_ctl),
        .count (cnt_val)
    );

endmodule

// File: rtl/pin_hold_chk.sv
module pin_hold_chk #(
    parameter int unsigned CNT_W = 29,
    parameter int unsigned REG_W = 32,
    parameter int unsigned CLR_B = 31
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             level
);

    localparam logic [REG_W-1:0] TOP_VAL = REG_W'({CNT_W{1'b1}});

    logic clr_req;
    assign clr_req = wr_en & wr_data[CLR_B];

    // R10
    reset_zero_chk: assert property (@(posedge clk) rst |=> rd_data == '0);

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> rd_data == '0);

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (level && !clr_req) |=> $stable(rd_data));

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!level && !clr_req && rd_data != TOP_VAL) |=> rd_data == $past(rd_data) + 1'b1);

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data == TOP_VAL && !clr_req) |=> rd_data == TOP_VAL);

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~TOP_VAL) == '0);

endmodule

bind pin_hold_meter pin_hold_chk #(
    .CNT_W (CNT_W),
    .REG_W (pin_hold_pkg::REG_WIDTH),
    .CLR_B (pin_hold_pkg::CLR_CMD_BIT)
) u_pin_hold_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .level   (sync_level)
);

// File: tb/test_pin_hold_meter.sv
module test_pin_hold_meter;
    import pin_hold_pkg::*;

    localparam int unsigned TW    = 10;
    localparam int unsigned TMAX  = (1 << TW) - 1;
    localparam int unsigned LIMIT = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pin_hold_meter #(.CNT_W(TW), .SYNC_STAGES(2)) i_pin_hold_meter (
        .clk     (clk),
        .rst     (rst),
        .pin_n   (pin_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    // Cycle model built from the requirements: two sync flops, clear first
    logic          m_s1 = 1'b1, m_s2 = 1'b1;
    logic [TW-1:0] m_cnt = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_cnt <= '0;
        end else begin
            m_s1 <= pin_n;
            m_s2 <= m_s1;
            if (wr_en && wr_data[31])               m_cnt <= '0;
            else if (!m_s2 && m_cnt != TW'(TMAX))   m_cnt <= m_cnt + 1'b1;
        end
    end

    function automatic logic [31:0] expect_rd();
        return {{(32-TW){1'b0}}, m_cnt};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic tick(input logic p, input logic w, input logic [31:0] d, input string req);
        pin_n = p; wr_en = w; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        check(req, rd_data, expect_rd());
    endtask

    initial begin
        #(4 * LIMIT);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R10: count is zero during reset
        check("R10", rd_data, 32'h0);
        rst = 1'b0;
        repeat (4) tick(1'b1, 1'b0, 32'h0, "R10");

        // R2: synchronizer latency, explicit values
        tick(1'b0, 1'b0, 32'h0, "R2");
        check("R2", rd_data, 32'd0);
        tick(1'b0, 1'b0, 32'h0, "R2");
        check("R2", rd_data, 32'd0);
        tick(1'b0, 1'b0, 32'h0, "R2");
        check("R2", rd_data, 32'd1);
        // R1: one per cycle
        repeat (9) tick(1'b0, 1'b0, 32'h0, "R1");
        check("R1", rd_data, 32'd10);

        // R3: release, two more counts pass the synchronizer, then hold
        repeat (12) tick(1'b1, 1'b0, 32'h0, "R3");
        check("R3", rd_data, 32'd12);
        // R8: writes without the clear bit are ignored
        tick(1'b1, 1'b1, 32'h7FFF_FFFF, "R8");
        tick(1'b1, 1'b0, 32'h0, "R8");
        check("R8", rd_data, 32'd12);
        // R4: resume from held value
        repeat (7) tick(1'b0, 1'b0, 32'h0, "R4");
        repeat (2) tick(1'b1, 1'b0, 32'h0, "R4");
        check("R4", rd_data, 32'd19);

        // R6: clear while released
        tick(1'b1, 1'b1, 32'h8000_0000, "R6");
        check("R6", rd_data, 32'd0);

        // R5: saturate at all ones, then hold there
        repeat (TMAX + 40) tick(1'b0, 1'b0, 32'h0, "R5");
        check("R5", rd_data, TMAX);
        // R9: nothing above the count field
        check("R9", rd_data & ~32'(TMAX), 32'h0);
        // R7: clear wins while still counting
        tick(1'b0, 1'b1, 32'hFFFF_FFFF, "R7");
        check("R7", rd_data, 32'd0);
        tick(1'b0, 1'b0, 32'h0, "R7");
        check("R7", rd_data, 32'd1);
        repeat (4) tick(1'b1, 1'b0, 32'h0, "R3");

        // R11: default width covers 21 whole seconds
        check("R11", 32'(((64'd1 << 29) - 1) >= secs_to_ticks(21)), 32'd1);

        // Random pin runs mixed with random writes (R1 R3 R4 R6 R8)
        for (int run = 0; run < 400; run++) begin
            logic p;
            int   len;
            p   = $urandom_range(0, 1);
            len = $urandom_range(1, 20);
            for (int c = 0; c < len; c++) begin
                logic        w;
                logic [31:0] d;
                w = ($urandom_range(0, 9) == 0);
                d = $urandom;
                if ($urandom_range(0, 3) != 0) d[31] = 1'b0;
                tick(p, w, d, "R1R3R4R6R8 random");
            end
        end

        finish_run();
    end

endmodule